// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block caches translations from virtual page numbers to physical frame numbers for a processor's memory management path. Each lookup carries a page number and the identifier of the address space that issued it. Every stored entry is compared with the request at the same time, so the answer arrives one clock later no matter how many entries the cache holds. The answer is a hit flag, the frame number and the index of the matching slot.

When a lookup misses, an external table walker finds the translation and writes it back through the refill port as a page, identifier and frame triple. The refill goes into an empty slot if one exists. Otherwise it overwrites the slot that has gone unused the longest. Entries carry the address space identifier, so a context switch needs no flush: the old process's entries stay in place and drop out one at a time as refills replace them. A flush input empties the whole cache in one cycle.

Top module: `xlat_cache`

## Requirements
- R1: After reset every slot is empty. While reset is held `rsp_valid` and `rsp_hit` are 0, and a lookup into the empty cache misses.
- R2: A lookup presented with `lk_valid` high in one cycle produces `rsp_valid` high in the next cycle. `rsp_valid` is low in a cycle that follows one with no lookup.
- R3: A hit requires both the page number and the address space identifier of a valid slot to equal the request. On a hit the response gives that slot's frame number in `rsp_pfn` and its position in `rsp_idx`. On a miss both fields read 0.
- R4: A valid slot whose page number matches but whose identifier differs gives a miss. A later refill for the new identifier coexists with the old slot.
- R5: A refill writes the lowest-numbered empty slot when any slot is empty, so refills into an empty cache fill slots 0, 1, 2 and so on in order.
- R6: When no slot is empty, a refill overwrites the least recently used slot.
- R7: A lookup that hits makes its slot the most recently used.
- R8: A refill makes the slot it writes the most recently used.
- R9: A flush empties every slot in one cycle. A refill presented in the same cycle as a flush is dropped.
- R10: A lookup in the same cycle as a refill or a flush is answered from the contents as they stood before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empty all slots |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Address space identifier of the request |
| fill_en | input | 1 | Refill strobe |
| fill_vpn | input | VPN_W | Page number of the refill |
| fill_asid | input | ASID_W | Address space identifier of the refill |
| fill_pfn | input | PFN_W | Frame number of the refill |
| rsp_valid | output | 1 | Lookup response strobe |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pfn | output | PFN_W | Frame number on a hit, else 0 |
| rsp_idx | output | $clog2(ENTRIES) | Slot index on a hit, else 0 |

## Verification
Every lookup result is due exactly one cycle after its request. The bench drives the request on a falling edge, lets one rising edge pass and samples the response on the next falling edge. A refill or flush changes state at the rising edge where it is presented, so the first lookup that can see the change is the one presented in the following cycle. Same-cycle cases drive the lookup and the refill or flush on the same falling edge and expect the old contents. Replacement order is never read from inside the block. The bench infers it from the `rsp_idx` that a later lookup returns for each refilled page, checked against an age order kept in the test tasks.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   // Supported range of slot counts
   localparam int unsigned XLAT_MIN_SLOTS = 16;
   localparam int unsigned XLAT_MAX_SLOTS = 512;

   // Index width for a given slot count, at least one bit
   function automatic int unsigned idx_width(input int unsigned slots);
      return (slots < 2) ? 1 : $clog2(slots);
   endfunction
endpackage

// File: rtl/xlat_match.sv
module xlat_match
   import xlat_pkg::*;
#(
   parameter int unsigned ENTRIES = 16,
   parameter int unsigned VPN_W   = 20,
   parameter int unsigned ASID_W  = 8,
   localparam int unsigned IDX_W  = idx_width(ENTRIES)
) (
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic [VPN_W-1:0]   slot_vpn  [ENTRIES],
   input  logic [ASID_W-1:0]  slot_asid [ENTRIES],
   input  logic [VPN_W-1:0]   req_vpn,
   input  logic [ASID_W-1:0]  req_asid,
   output logic               any_hit,
   output logic [IDX_W-1:0]   hit_idx
);
   logic [ENTRIES-1:0] hit_vec;

   // One comparator per slot, all working in parallel
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = valid_vec[g]
                          && (slot_vpn[g] == req_vpn)
                          && (slot_asid[g] == req_asid);
   end

   assign any_hit = |hit_vec;

   // Lowest matching slot wins should the walker ever refill a duplicate
   always_comb begin
      hit_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (hit_vec[i]) hit_idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/xlat_lru.sv
module xlat_lru
   import xlat_pkg::*;
#(
   parameter int unsigned ENTRIES = 16,
   localparam int unsigned IDX_W  = idx_width(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic               touch_hit,
   input  logic [IDX_W-1:0]   hit_idx,
   input  logic               touch_fill,
   output logic [IDX_W-1:0]   fill_idx
);
   localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(ENTRIES - 1);

   // Ages form a permutation of 0..ENTRIES-1; 0 is most recent
   logic [IDX_W-1:0] age_q [ENTRIES];
   logic [IDX_W-1:0] age_a [ENTRIES];
   logic [IDX_W-1:0] age_d [ENTRIES];
   logic [IDX_W-1:0] free_idx, old_idx;
   logic             any_free;
   logic [ENTRIES-1:0] mru_vec;

   // Lowest empty slot, else the oldest slot
   always_comb begin
      free_idx = '0;
      any_free = 1'b0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!valid_vec[i]) begin
            free_idx = IDX_W'(i);
            any_free = 1'b1;
         end
      end
      old_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (age_q[i] == AGE_MAX) old_idx = IDX_W'(i);
      end
   end

   assign fill_idx = any_free ? free_idx : old_idx;

   // Two ordered promotions: the hit first, then the refill
   always_comb begin
      for (int i = 0; i < ENTRIES; i++) begin
         age_a[i] = age_q[i];
         if (touch_hit) begin
            if (IDX_W'(i) == hit_idx)              age_a[i] = '0;
            else if (age_q[i] < age_q[hit_idx])    age_a[i] = age_q[i] + IDX_W'(1);
         end
      end
      for (int i = 0; i < ENTRIES; i++) begin
         age_d[i] = age_a[i];
         if (touch_fill) begin
            if (IDX_W'(i) == fill_idx)             age_d[i] = '0;
            else if (age_a[i] < age_a[fill_idx])   age_d[i] = age_a[i] + IDX_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
      end else begin
         for (int i = 0; i < ENTRIES; i++) age_q[i] <= age_d[i];
      end
   end

   always_comb begin
      for (int i = 0; i < ENTRIES; i++) mru_vec[i] = (age_q[i] == '0);
   end

   // The age order keeps exactly one most recent slot
   assert_single_mru_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mru_vec) == 1);

   // A hit alone leaves its slot as most recent
   assert_hit_promotes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (touch_hit && !touch_fill) |=> (age_q[$past(hit_idx)] == '0));

   // A refill leaves its slot as most recent
   assert_fill_promotes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      touch_fill |=> (age_q[$past(fill_idx)] == '0));

   // An empty slot is always chosen before an occupied one
   assert_free_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_vec != '1) |-> !valid_vec[fill_idx]);
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
   import xlat_pkg::*;
#(
   parameter int unsigned ENTRIES = 16,
   parameter int unsigned VPN_W   = 20,
   parameter int unsigned PFN_W   = 20,
   parameter int unsigned ASID_W  = 8,
   localparam int unsigned IDX_W  = idx_width(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              lk_valid,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic              fill_en,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [ASID_W-1:0] fill_asid,
   input  logic [PFN_W-1:0]  fill_pfn,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [PFN_W-1:0]  rsp_pfn,
   output logic [IDX_W-1:0]  rsp_idx
);
   // Elaboration-time parameter checks
   if (ENTRIES < XLAT_MIN_SLOTS || ENTRIES > XLAT_MAX_SLOTS) begin : g_bad_entries
      $error("xlat_cache: ENTRIES out of supported range");
   end
   if (VPN_W < 1 || PFN_W < 1 || ASID_W < 1) begin : g_bad_width
      $error("xlat_cache: field widths must be positive");
   end

   logic [ENTRIES-1:0] valid_q;
   logic [VPN_W-1:0]   vpn_q  [ENTRIES];
   logic [ASID_W-1:0]  asid_q [ENTRIES];
   logic [PFN_W-1:0]   pfn_q  [ENTRIES];

   logic             m_hit;
   logic [IDX_W-1:0] m_idx;
   logic [IDX_W-1:0] victim;
   logic             fill_go;
   logic             lk_hit;

   assign fill_go = fill_en && !flush;
   assign lk_hit  = lk_valid && m_hit;

   xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
      .valid_vec (valid_q),
      .slot_vpn  (vpn_q),
      .slot_asid (asid_q),
      .req_vpn   (lk_vpn),
      .req_asid  (lk_asid),
      .any_hit   (m_hit),
      .hit_idx   (m_idx)
   );

   xlat_lru #(.ENTRIES(ENTRIES)) u_lru (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid_vec  (valid_q),
      .touch_hit  (lk_hit),
      .hit_idx    (m_idx),
      .touch_fill (fill_go),
      .fill_idx   (victim)
   );

   // Valid bits: flush beats refill
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (flush) begin
         valid_q <= '0;
      end else if (fill_go) begin
         valid_q[victim] <= 1'b1;
      end
   end

   // Per-slot payload, written only by a refill aimed at it
   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (fill_go && (victim == IDX_W'(g))) begin
            vpn_q[g]  <= fill_vpn;
            asid_q[g] <= fill_asid;
            pfn_q[g]  <= fill_pfn;
         end
      end
   end

   // Registered response from the pre-update contents
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_pfn   <= '0;
         rsp_idx   <= '0;
      end else begin
         rsp_valid <= lk_valid;
         rsp_hit   <= lk_hit;
         rsp_pfn   <= lk_hit ? pfn_q[m_idx] : '0;
         rsp_idx   <= lk_hit ? m_idx : '0;
      end
   end

   assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid);

   assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rsp_valid);

   assert_empty_misses_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q == '0) |=> !rsp_hit);

   assert_miss_fields_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_hit |-> (rsp_pfn == '0 && rsp_idx == '0));

   assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_q == '0));

   assert_fill_marks_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fill_go |=> valid_q[$past(victim)]);
endmodule

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;
   localparam int unsigned N = 16;
   localparam int unsigned IW = $clog2(N);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 1'b0;
   logic lk_valid = 1'b0;
   logic [19:0] lk_vpn = '0;
   logic [7:0]  lk_asid = '0;
   logic fill_en = 1'b0;
   logic [19:0] fill_vpn = '0;
   logic [7:0]  fill_asid = '0;
   logic [19:0] fill_pfn = '0;
   logic rsp_valid, rsp_hit;
   logic [19:0] rsp_pfn;
   logic [IW-1:0] rsp_idx;

   int nchk = 0;
   int nbad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;  // 250 MHz

   xlat_cache #(.ENTRIES(N)) u0 (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
      .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_pfn(fill_pfn),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pfn(rsp_pfn), .rsp_idx(rsp_idx)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Lookup, then sample one cycle later: {valid,hit,pfn,idx}
   task automatic lookup(input logic [19:0] vpn, input logic [7:0] asid,
                         input bit eh, input logic [19:0] epfn, input int eidx,
                         input string req);
      logic [63:0] act, exp;
      @(negedge clk);
      lk_valid = 1'b1; lk_vpn = vpn; lk_asid = asid;
      @(negedge clk);
      lk_valid = 1'b0;
      act = {rsp_valid, rsp_hit, rsp_pfn, 8'(rsp_idx)};
      exp = {1'b1, eh, eh ? epfn : 20'h0, eh ? 8'(eidx) : 8'h0};
      check(act == exp, req, "lookup {valid,hit,pfn,idx}", act, exp);
   endtask

   task automatic refill(input logic [19:0] vpn, input logic [7:0] asid, input logic [19:0] pfn);
      @(negedge clk);
      fill_en = 1'b1; fill_vpn = vpn; fill_asid = asid; fill_pfn = pfn;
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic pulse_flush();
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(rsp_valid == 1'b0 && rsp_hit == 1'b0, "R1", "outputs in reset",
            {rsp_valid, rsp_hit}, 0);
      rst_n = 1'b1;
      lookup(20'h00010, 8'd1, 1'b0, 0, 0, "R1");
   endtask

   task automatic t_fill_order();
      for (int i = 0; i < 3; i++) refill(20'h00100 + 20'(i), 8'd3, 20'h00500 + 20'(i));
      lookup(20'h00101, 8'd3, 1'b1, 20'h00501, 1, "R5");
      lookup(20'h00102, 8'd3, 1'b1, 20'h00502, 2, "R3");
      lookup(20'h00100, 8'd3, 1'b1, 20'h00500, 0, "R3");
      // no lookup in this cycle: response strobe must drop
      @(negedge clk);
      check(rsp_valid == 1'b0, "R2", "idle rsp_valid", rsp_valid, 0);
      lookup(20'h00103, 8'd3, 1'b0, 0, 0, "R3");
   endtask

   task automatic t_lru();
      pulse_flush();
      for (int i = 0; i < N; i++) refill(20'h00010 + 20'(i), 8'd1, 20'h00200 + 20'(i));
      lookup(20'h0001F, 8'd1, 1'b1, 20'h0020F, 15, "R5");
      lookup(20'h00010, 8'd1, 1'b1, 20'h00200, 0, "R7");
      // full: oldest is now slot 1, then slot 2
      refill(20'h00040, 8'd1, 20'h00A40);
      refill(20'h00041, 8'd1, 20'h00A41);
      lookup(20'h00040, 8'd1, 1'b1, 20'h00A40, 1, "R6");
      lookup(20'h00041, 8'd1, 1'b1, 20'h00A41, 2, "R8");
      lookup(20'h00011, 8'd1, 1'b0, 0, 0, "R6");
      lookup(20'h00012, 8'd1, 1'b0, 0, 0, "R8");
   endtask

   task automatic t_asid();
      // oldest slot now 3 (order 3..15,0,1,2)
      lookup(20'h00010, 8'd2, 1'b0, 0, 0, "R4");
      refill(20'h00010, 8'd2, 20'h00999);
      lookup(20'h00010, 8'd2, 1'b1, 20'h00999, 3, "R4");
      lookup(20'h00010, 8'd1, 1'b1, 20'h00200, 0, "R4");
   endtask

   task automatic t_same_cycle();
      logic [63:0] act;
      pulse_flush();
      @(negedge clk);
      fill_en = 1'b1; fill_vpn = 20'h00007; fill_asid = 8'd2; fill_pfn = 20'h00077;
      lk_valid = 1'b1; lk_vpn = 20'h00007; lk_asid = 8'd2;
      @(negedge clk);
      fill_en = 1'b0; lk_valid = 1'b0;
      act = {rsp_valid, rsp_hit};
      check(act == 64'h2, "R10", "lookup beside refill", act, 64'h2);
      lookup(20'h00007, 8'd2, 1'b1, 20'h00077, 0, "R10");
      // lookup beside a flush still sees the old slot
      @(negedge clk);
      flush = 1'b1; lk_valid = 1'b1; lk_vpn = 20'h00007; lk_asid = 8'd2;
      @(negedge clk);
      flush = 1'b0; lk_valid = 1'b0;
      act = {rsp_valid, rsp_hit, rsp_pfn};
      check(act == {2'b11, 20'h00077}, "R10", "lookup beside flush", act, {2'b11, 20'h00077});
      lookup(20'h00007, 8'd2, 1'b0, 0, 0, "R9");
   endtask

   task automatic t_flush();
      refill(20'h00020, 8'd4, 20'h00120);
      pulse_flush();
      lookup(20'h00020, 8'd4, 1'b0, 0, 0, "R9");
      @(negedge clk);
      flush = 1'b1; fill_en = 1'b1; fill_vpn = 20'h00005; fill_asid = 8'd4; fill_pfn = 20'h00055;
      @(negedge clk);
      flush = 1'b0; fill_en = 1'b0;
      lookup(20'h00005, 8'd4, 1'b0, 0, 0, "R9");
      refill(20'h00006, 8'd4, 20'h00066);
      lookup(20'h00006, 8'd4, 1'b1, 20'h00066, 0, "R9");
   endtask

   initial begin
      t_reset();
      t_fill_order();
      t_lru();
      t_asid();
      t_same_cycle();
      t_flush();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         nchk++; nbad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end
endmodule